// File: doc/BRIEF.md
# Sprite Horizontal Position Serializer

This block turns the per-line register state of four 8-pixel players and four 2-pixel missiles into one pixel bit per object per color clock. Every object compares its horizontal position register with a free-running color-clock counter that the display timing supplies. When the two are equal, the object copies its graphics bits into a private shift register and sends them out leftmost bit first, holding each bit for one, two or four color clocks as its size code selects. The pixel bits go on to the priority and color logic.

A byte-wide write port loads the position, size and graphics registers. Each object runs a two-state machine. `S_IDLE` shows nothing and leaves on the *load* transition (counter equals position) into `S_SHIFT`. `S_SHIFT` takes the *stretch* transition to repeat the current bit and the *advance* transition to step to the next bit. It takes the *finish* transition back to `S_IDLE` after the last copy of the last bit. It takes the *clip* transition back to `S_IDLE` when the counter wraps to zero. A *retrigger* transition from `S_SHIFT` to itself starts the object over when a new position match occurs during the shift.

Because the graphics are copied when the match occurs, a graphics write made while an object is on screen has no effect until that object's next match. Horizontal scrolling of the playfield does not move these objects. Only the position registers place them.

Top module: `sprite_hpos_serializer`

## Requirements
- R1: After reset, every position, size and graphics register is zero and every pixel output is 0.
- R2: A write with `wr_en` high loads `wr_data` into one register. Addresses 0..3 hold the player positions, 4..7 the missile positions and 8..11 the player size codes (data bits 1..0). Address 12 holds the shared missile size byte, with missile n in bits 2n+1..2n. Addresses 13..16 hold the player graphics and address 17 the shared missile graphics byte. Addresses 18..31 change nothing.
- R3: An object's first pixel is the color clock equal to its position register. The pixel for color clock X is presented on the clock cycle after the one in which `hcount` equals X.
- R4: Player graphics bit 7 is the leftmost pixel and bit 0 the rightmost.
- R5: A player size code of 00 or 10 gives 8 color clocks, 01 gives 16 and 11 gives 32. Each graphics bit covers width/8 consecutive color clocks.
- R6: Missile size codes give 2 color clocks (00 or 10), 4 (01) or 8 (11). Each bit covers width/2 color clocks.
- R7: Missile n uses bits 2n+1..2n of the shared graphics byte. The upper bit of the pair is the left pixel.
- R8: Graphics are copied at the position match. A graphics write in the match cycle or later in the line shows at the object's next match.
- R9: An object still shifting when `hcount` wraps to zero is cut off at color clock 255 and shows nothing at the start of the next line.
- R10: A position match while an object is shifting restarts that object from its first bit with fresh graphics and size.
- R11: Outside its stretched extent an object's pixel output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color-clock rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | 8 | Color-clock counter, one step per cycle, wrapping 255 to 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register select |
| wr_data | input | 8 | Register write data |
| player_pix | output | 4 | Pixel bit of players 3..0 |
| missile_pix | output | 4 | Pixel bit of missiles 3..0 |

## Verification
A graphics register write and that object's position match can fall in the same clock cycle. The bench provokes this by writing a player's graphics in exactly the cycle in which `hcount` equals its position. It then judges the captured line against the old graphics value and the following line against the new one. A second collision, a position write that creates a new match while the object is still shifting, is judged by a line that shows the truncated first copy followed by a full second copy.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_SHIFT = 1'b1
    } ser_state_e;

    // extra repeats of each graphics bit for a 2-bit size code
    function automatic logic [1:0] extra_reps(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'b01:   r = 2'd1;
            2'b11:   r = 2'd3;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/obj_serializer.sv
module obj_serializer
    import sprite_pkg::*;
#(
    parameter int GW  = 8,
    parameter int HCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HCW-1:0] hcount,
    input  logic [HCW-1:0] hpos,
    input  logic [GW-1:0]  gfx,
    input  logic [1:0]     size,
    output logic           pix
);

    localparam int BCW = (GW > 1) ? $clog2(GW) : 1;

    ser_state_e     state, state_nx;
    logic [GW-1:0]  shreg;
    logic [1:0]     rep_cnt, rep_max;
    logic [BCW-1:0] bit_cnt;
    logic           hit, wrap, last;

    assign hit  = (hcount == hpos);
    assign wrap = (hcount == '0);
    assign last = (rep_cnt == 2'd0) && (bit_cnt == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (hit) state_nx = S_SHIFT;
            S_SHIFT: begin
                if (hit)       state_nx = S_SHIFT;   // retrigger
                else if (wrap) state_nx = S_IDLE;    // clip
                else if (last) state_nx = S_IDLE;    // finish
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            rep_cnt <= '0;
            rep_max <= '0;
            bit_cnt <= '0;
        end else if (hit) begin
            shreg   <= gfx;
            rep_max <= extra_reps(size);
            rep_cnt <= extra_reps(size);
            bit_cnt <= BCW'(GW - 1);
        end else if (state == S_SHIFT && !wrap) begin
            if (rep_cnt != 2'd0) begin
                rep_cnt <= rep_cnt - 2'd1;
            end else if (bit_cnt != '0) begin
                shreg   <= {shreg[GW-2:0], 1'b0};
                bit_cnt <= bit_cnt - 1'b1;
                rep_cnt <= rep_max;
            end
        end
    end

    always_comb begin
        pix = (state == S_SHIFT) && shreg[GW-1];
    end

    p_match_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state == S_SHIFT) && (bit_cnt == BCW'(GW - 1)));

    p_wrap_clips_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && wrap && !hit) |=> (state == S_IDLE));

    p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && !hit && !wrap && rep_cnt != 2'd0) |=> $stable(shreg));

    p_rep_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rep_cnt <= rep_max);

    p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !hit) |=> (state == S_IDLE));

endmodule

// File: rtl/sprite_hpos_serializer.sv
module sprite_hpos_serializer
    import sprite_pkg::*;
#(
    parameter int HCW = 8,
    parameter int NPL = 4,
    parameter int NMS = 4,
    parameter int PGW = 8,
    parameter int MGW = 2,
    parameter int DW  = 8,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HCW-1:0] hcount,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic [NPL-1:0] player_pix,
    output logic [NMS-1:0] missile_pix
);

    localparam int MGB    = NMS * MGW;
    localparam int MSB_W  = NMS * 2;
    localparam int A_PPOS = 0;
    localparam int A_MPOS = A_PPOS + NPL;
    localparam int A_PSZ  = A_MPOS + NMS;
    localparam int A_MSZ  = A_PSZ + NPL;
    localparam int A_PGFX = A_MSZ + 1;
    localparam int A_MGFX = A_PGFX + NPL;

    logic [NPL-1:0][HCW-1:0] ppos;
    logic [NMS-1:0][HCW-1:0] mpos;
    logic [NPL-1:0][1:0]     psz;
    logic [MSB_W-1:0]        msz;
    logic [NPL-1:0][PGW-1:0] pgfx;
    logic [MGB-1:0]          mgfx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppos <= '0;
            mpos <= '0;
            psz  <= '0;
            msz  <= '0;
            pgfx <= '0;
            mgfx <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NPL; i++) begin
                if (wr_addr == AW'(A_PPOS + i)) ppos[i] <= wr_data[HCW-1:0];
                if (wr_addr == AW'(A_PSZ + i))  psz[i]  <= wr_data[1:0];
                if (wr_addr == AW'(A_PGFX + i)) pgfx[i] <= wr_data[PGW-1:0];
            end
            for (int i = 0; i < NMS; i++) begin
                if (wr_addr == AW'(A_MPOS + i)) mpos[i] <= wr_data[HCW-1:0];
            end
            if (wr_addr == AW'(A_MSZ))  msz  <= wr_data[MSB_W-1:0];
            if (wr_addr == AW'(A_MGFX)) mgfx <= wr_data[MGB-1:0];
        end
    end

    generate
        for (genvar p = 0; p < NPL; p++) begin : g_player
            obj_serializer #(.GW(PGW), .HCW(HCW)) u_ser (
                .clk    (clk),
                .rst_n  (rst_n),
                .hcount (hcount),
                .hpos   (ppos[p]),
                .gfx    (pgfx[p]),
                .size   (psz[p]),
                .pix    (player_pix[p])
            );
        end
        for (genvar m = 0; m < NMS; m++) begin : g_missile
            obj_serializer #(.GW(MGW), .HCW(HCW)) u_ser (
                .clk    (clk),
                .rst_n  (rst_n),
                .hcount (hcount),
                .hpos   (mpos[m]),
                .gfx    (mgfx[m*MGW +: MGW]),
                .size   (msz[m*2 +: 2]),
                .pix    (missile_pix[m])
            );
        end
    endgenerate

    p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({ppos, mpos, psz, msz, pgfx, mgfx}));

    p_unused_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > AW'(A_MGFX)) |=> $stable({ppos, mpos, psz, msz, pgfx, mgfx}));

endmodule

// File: tb/tb_sprite_hpos_serializer.sv
`timescale 1ns/1ps
module tb_sprite_hpos_serializer;

    typedef struct packed {
        logic [3:0][7:0] pp;
        logic [3:0][7:0] pg;
        logic [3:0][7:0] pz;
        logic [3:0][7:0] mp;
        logic [7:0]      mg;
        logic [7:0]      ms;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{pp:32'hB0805030, pg:32'h96C381A5, pz:32'h03020100, mp:32'hC8906040, mg:8'h9E, ms:8'hE4},
        '{pp:32'h10A07038, pg:32'hF0807E01, pz:32'h02010003, mp:32'hFCE03320, mg:8'h67, ms:8'hDB},
        '{pp:32'h333231F8, pg:32'h0F55FFAA, pz:32'h03000103, mp:32'hD00A0908, mg:8'h5A, ms:8'h1B},
        '{pp:32'h20406080, pg:32'h00003C00, pz:32'h01010101, mp:32'h11223344, mg:8'h00, ms:8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hcount = '0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] player_pix, missile_pix;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    vec_t cur = '0;
    logic [3:0] pl_line [256];
    logic [3:0] ms_line [256];

    always #2 clk = ~clk;

    sprite_hpos_serializer dut (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .player_pix(player_pix), .missile_pix(missile_pix)
    );

    function automatic int rep_of(input logic [1:0] code);
        return (code == 2'b01) ? 2 : (code == 2'b11) ? 4 : 1;
    endfunction

    function automatic logic exp_pix(input int x, input int pos, input logic [7:0] g,
                                     input int nb, input int rep);
        int idx;
        if (x < pos) return 1'b0;
        idx = (x - pos) / rep;
        if (idx >= nb) return 1'b0;
        return g[nb - 1 - idx];
    endfunction

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a <= 5'd3)       cur.pp[a]       = d;
        else if (a <= 5'd7)  cur.mp[a - 5'd4] = d;
        else if (a <= 5'd11) cur.pz[a - 5'd8] = d;
        else if (a == 5'd12) cur.ms = d;
        else if (a <= 5'd16) cur.pg[a - 5'd13] = d;
        else if (a == 5'd17) cur.mg = d;
    endtask

    task automatic load_vec(input vec_t v);
        for (int i = 0; i < 4; i++) begin
            wr_reg(5'(i), v.pp[i]);
            wr_reg(5'(4 + i), v.mp[i]);
            wr_reg(5'(8 + i), v.pz[i]);
            wr_reg(5'(13 + i), v.pg[i]);
        end
        wr_reg(5'd12, v.ms);
        wr_reg(5'd17, v.mg);
    endtask

    // walk one line; optional write in the cycle where hcount == wx
    task automatic run_line(input int wx, input logic [4:0] wa, input logic [7:0] wd);
        for (int x = 0; x < 256; x++) begin
            @(negedge clk);
            if (x > 0) begin
                pl_line[x-1] = player_pix;
                ms_line[x-1] = missile_pix;
            end
            hcount = x[7:0];
            if (x == wx) begin
                wr_en = 1'b1; wr_addr = wa; wr_data = wd;
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        pl_line[255] = player_pix;
        ms_line[255] = missile_pix;
        hcount = '0;
        wr_en = 1'b0;
    endtask

    task automatic check_obj(input string req, input bit is_m, input int i, input int pos,
                             input logic [7:0] g, input int nb, input int rep);
        logic got, ex;
        bit   bad = 1'b0;
        checks++;
        for (int x = 0; x < 256; x++) begin
            got = is_m ? ms_line[x][i] : pl_line[x][i];
            ex  = exp_pix(x, pos, g, nb, rep);
            if (!bad && got !== ex) begin
                bad = 1'b1;
                errors++;
                $display("FAIL %s %s%0d x=%0d actual %0b expected %0b",
                         req, is_m ? "M" : "P", i, x, got, ex);
            end
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 4; i++) begin
            check_obj(req, 1'b0, i, int'(cur.pp[i]), cur.pg[i], 8, rep_of(cur.pz[i][1:0]));
            check_obj(req, 1'b1, i, int'(cur.mp[i]), {6'b0, cur.mg[2*i +: 2]}, 2,
                      rep_of(cur.ms[2*i +: 2]));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        checks++;
        if (player_pix !== 4'h0 || missile_pix !== 4'h0) begin
            errors++;
            $display("FAIL R1 reset pixels actual %h/%h expected 0/0", player_pix, missile_pix);
        end
        run_line(-1, '0, '0);
        check_all("R1");

        // table walk: R3 R4 R5 R6 R7 R9 R11 (second of two back-to-back lines)
        for (int v = 0; v < 4; v++) begin
            load_vec(VECS[v]);
            run_line(-1, '0, '0);
            run_line(-1, '0, '0);
            check_all("R3/R4/R5/R6/R7/R9/R11");
        end

        // R8 graphics write later in the line than the match
        load_vec(VECS[0]);
        run_line(-1, '0, '0);
        run_line(8'h33, 5'd13, 8'h0F);
        check_obj("R8 midline", 1'b0, 0, 8'h30, 8'hA5, 8, 1);
        cur.pg[0] = 8'h0F;
        run_line(-1, '0, '0);
        check_obj("R8 next line", 1'b0, 0, 8'h30, 8'h0F, 8, 1);
        // R8 graphics write in the match cycle
        run_line(8'h30, 5'd13, 8'hF0);
        check_obj("R8 same cycle", 1'b0, 0, 8'h30, 8'h0F, 8, 1);
        cur.pg[0] = 8'hF0;
        run_line(-1, '0, '0);
        check_obj("R8 after same cycle", 1'b0, 0, 8'h30, 8'hF0, 8, 1);

        // R10 retrigger by a position write during the shift
        wr_reg(5'd3, 8'h60);
        wr_reg(5'd11, 8'h03);
        wr_reg(5'd16, 8'h80);
        run_line(-1, '0, '0);
        run_line(8'h62, 5'd3, 8'h70);
        begin
            logic ex;
            bit bad = 1'b0;
            checks++;
            for (int x = 0; x < 256; x++) begin
                ex = (x < 8'h70) ? exp_pix(x, 8'h60, 8'h80, 8, 4) : exp_pix(x, 8'h70, 8'h80, 8, 4);
                if (!bad && pl_line[x][3] !== ex) begin
                    bad = 1'b1;
                    errors++;
                    $display("FAIL R10 x=%0d actual %0b expected %0b", x, pl_line[x][3], ex);
                end
            end
        end
        cur.pp[3] = 8'h70;

        // R2 unused addresses change nothing
        wr_reg(5'd18, 8'hFF);
        wr_reg(5'd31, 8'h00);
        run_line(-1, '0, '0);
        run_line(-1, '0, '0);
        check_all("R2 unused");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule